// File: doc/BRIEF.md
# Trap Entry and Return State Logic

This block is the combinational heart of a trap unit in a 64-bit processor whose registers use MSB-0 bit numbering (bit 0 is the most significant bit). Each cycle it looks at the current instruction address, the machine state register and the two save/restore registers, and at a two-bit operation code. From these it produces a next instruction address, a new machine state value and new save/restore values. Each result has its own valid flag, so the surrounding pipeline knows which registers to write back.

On a trap entry the block saves two things. The first save register gets the address of the following instruction. The second gets a copy of the machine state with two reserved bit groups cleared. On a return from interrupt the block does not simply copy the second save register into the machine state. It merges the two under rules that depend on privilege. Hypervisor state can be kept but never gained. A return to problem state always switches interrupts and address translation on. The machine-check enable can only be changed from hypervisor state. The return address has its low two bits cleared.

Operand fetch, writeback, pipelining and vector address selection stay outside this block.

Top module: `trap_msr_core`

## Requirements
- R1: Operation code 2'b01 is trap entry: `srr0_ok` and `srr1_ok` are 1, while `nia_ok` and `msr_ok` are 0. Operation code 2'b10 is return from interrupt: `nia_ok` and `msr_ok` are 1, while `srr0_ok` and `srr1_ok` are 0.
- R2: On trap entry, `srr0_o` equals `cia_i` + 4 modulo 2^64.
- R3: On trap entry, `srr1_o` bits 33..36 and 42..47 (MSB-0) are 0.
- R4: On trap entry, every other bit of `srr1_o` (MSB-0 0..32, 37..41, 48..63) equals the same bit of `msr_i`.
- R5: On return, `nia_o` equals `srr0_i` with its two least significant bits (MSB-0 62 and 63) cleared.
- R6: On return, the hypervisor bit (MSB-0 3) of `msr_o` is the AND of that bit in `srr1_i` and in `msr_i`.
- R7: On return, the external-interrupt enable (MSB-0 48), instruction translation (MSB-0 58) and data translation (MSB-0 59) bits of `msr_o` are each the OR of the matching `srr1_i` bit with the `srr1_i` problem-state bit (MSB-0 49).
- R8: On return, the machine-check enable (MSB-0 51) of `msr_o` comes from `srr1_i` when the `msr_i` hypervisor bit is 1, and from `msr_i` otherwise.
- R9: On return, every other `msr_o` bit is copied from `srr1_i`. This includes problem state, MSB-0 bits 29..31 and MSB-0 bits 60..63.
- R10: Operation codes 2'b00 and 2'b11 set all four valid flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Operation: 01 trap entry, 10 return, others idle |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state register |
| srr0_i | input | 64 | Saved return address |
| srr1_i | input | 64 | Saved machine state |
| nia_o | output | 64 | Next instruction address |
| nia_ok | output | 1 | Next address is valid |
| msr_o | output | 64 | New machine state |
| msr_ok | output | 1 | New machine state is valid |
| srr0_o | output | 64 | New saved return address |
| srr0_ok | output | 1 | New SRR0 is valid |
| srr1_o | output | 64 | New saved machine state |
| srr1_ok | output | 1 | New SRR1 is valid |

## Verification
The block holds no state, so a wrong merge rule shows up on the outputs in the same cycle as the inputs that expose it. Most of these faults only appear under particular privilege combinations. A wrong hypervisor AND or machine-check selection is visible only when the current hypervisor bit and the saved bit differ. A missing problem-state OR is visible only with the saved problem-state bit set and the enables clear. The sweep therefore forces every combination of current hypervisor bit and saved problem-state bit, with random values in all other bits. It compares each result bit against a model written bit by bit in MSB-0 numbering.

// File: rtl/trap_msr_core.sv
module trap_msr_core #(
  parameter int HV_BIT = 3,
  parameter int EE_BIT = 48,
  parameter int PR_BIT = 49,
  parameter int ME_BIT = 51,
  parameter int IR_BIT = 58,
  parameter int DR_BIT = 59
) (
  input  logic [1:0]  op_i,
  input  logic [63:0] cia_i,
  input  logic [63:0] msr_i,
  input  logic [63:0] srr0_i,
  input  logic [63:0] srr1_i,
  output logic [63:0] nia_o,
  output logic        nia_ok,
  output logic [63:0] msr_o,
  output logic        msr_ok,
  output logic [63:0] srr0_o,
  output logic        srr0_ok,
  output logic [63:0] srr1_o,
  output logic        srr1_ok
);
  localparam int W = 64;
  localparam logic [1:0] OP_TRAP = 2'b01;
  localparam logic [1:0] OP_RET  = 2'b10;
  localparam int HV = W - 1 - HV_BIT;
  localparam int EE = W - 1 - EE_BIT;
  localparam int PR = W - 1 - PR_BIT;
  localparam int ME = W - 1 - ME_BIT;
  localparam int IR = W - 1 - IR_BIT;
  localparam int DR = W - 1 - DR_BIT;

  function automatic logic [W-1:0] keep_mask();
    logic [W-1:0] m;
    for (int n = 0; n < W; n++)
      m[W-1-n] = !((n >= 33 && n <= 36) || (n >= 42 && n <= 47));
    return m;
  endfunction

  localparam logic [W-1:0] SRR1_KEEP = keep_mask();

  logic is_trap, is_ret;
  logic [W-1:0] merged;

  assign is_trap = (op_i == OP_TRAP);
  assign is_ret  = (op_i == OP_RET);

  assign srr0_ok = is_trap;
  assign srr1_ok = is_trap;
  assign nia_ok  = is_ret;
  assign msr_ok  = is_ret;

  assign srr0_o = cia_i + 64'd4;
  assign srr1_o = msr_i & SRR1_KEEP;
  assign nia_o  = {srr0_i[W-1:2], 2'b00};

  always_comb begin
    merged     = srr1_i;
    merged[HV] = srr1_i[HV] & msr_i[HV];
    merged[EE] = srr1_i[EE] | srr1_i[PR];
    merged[IR] = srr1_i[IR] | srr1_i[PR];
    merged[DR] = srr1_i[DR] | srr1_i[PR];
    merged[ME] = msr_i[HV] ? srr1_i[ME] : msr_i[ME];
  end

  assign msr_o = merged;

  always_comb begin
    if (op_i == 2'b00 || op_i == 2'b11)
      AST_IDLE_QUIET: assert (!nia_ok && !msr_ok && !srr0_ok && !srr1_ok); // R10
    if (nia_ok)
      AST_NIA_ALIGNED: assert (nia_o[1:0] == 2'b00); // R5
    if (msr_ok && msr_i[HV] == 1'b0)
      AST_HV_NO_GAIN: assert (msr_o[HV] == 1'b0); // R6
    if (msr_ok && msr_o[PR])
      AST_PROBLEM_ENABLES: assert (msr_o[EE] && msr_o[IR] && msr_o[DR]); // R7
    if (msr_ok && msr_i[HV] == 1'b0)
      AST_ME_LOCKED: assert (msr_o[ME] == msr_i[ME]); // R8
    if (srr1_ok)
      AST_SRR1_HOLES: assert ((srr1_o & ~SRR1_KEEP) == '0); // R3
    if (srr0_ok || srr1_ok)
      AST_EXCLUSIVE: assert (!nia_ok && !msr_ok); // R1
  end
endmodule

// File: tb/sim_trap_msr_core.sv
module sim_trap_msr_core;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  op = 2'b00;
  logic [63:0] cia = '0, msr = '0, srr0 = '0, srr1 = '0;
  logic [63:0] nia, msr_n, srr0_n, srr1_n;
  logic nia_ok, msr_ok, srr0_ok, srr1_ok;
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  trap_msr_core u0 (
    .op_i(op), .cia_i(cia), .msr_i(msr), .srr0_i(srr0), .srr1_i(srr1),
    .nia_o(nia), .nia_ok(nia_ok), .msr_o(msr_n), .msr_ok(msr_ok),
    .srr0_o(srr0_n), .srr0_ok(srr0_ok), .srr1_o(srr1_n), .srr1_ok(srr1_ok)
  );

  function automatic logic b(logic [63:0] x, int n);
    return x[63-n];
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s op=%b actual=%h expected=%h", req, op, act, exp);
    end
  endtask

  task automatic verify();
    logic [63:0] e_srr1, e_msr, e_nia;
    logic hv_c;
    for (int n = 0; n < 64; n++) begin
      e_srr1[63-n] = ((n >= 33 && n <= 36) || (n >= 42 && n <= 47)) ? 1'b0 : b(msr, n);
      case (n)
        3:          e_msr[63-n] = b(srr1, 3) & b(msr, 3);
        48, 58, 59: e_msr[63-n] = b(srr1, n) | b(srr1, 49);
        51:         e_msr[63-n] = b(msr, 3) ? b(srr1, 51) : b(msr, 51);
        default:    e_msr[63-n] = b(srr1, n);
      endcase
    end
    e_nia = srr0 - (srr0 % 64'd4);
    hv_c = b(msr, 3);
    if (op == 2'b01) begin
      check("R1", {60'd0, nia_ok, msr_ok, srr0_ok, srr1_ok}, 64'b0011);
      check("R2", srr0_n, cia + 64'd4);
      check("R3", srr1_n & ~e_srr1, 64'd0);
      check("R4", srr1_n, e_srr1);
    end else if (op == 2'b10) begin
      check("R1", {60'd0, nia_ok, msr_ok, srr0_ok, srr1_ok}, 64'b1100);
      check("R5", nia, e_nia);
      check("R6", {63'd0, b(msr_n, 3)}, {63'd0, e_msr[60]});
      check("R7", {61'd0, b(msr_n, 48), b(msr_n, 58), b(msr_n, 59)},
            {61'd0, e_msr[15], e_msr[5], e_msr[4]});
      check(hv_c ? "R8 hv=1" : "R8 hv=0", {63'd0, b(msr_n, 51)}, {63'd0, e_msr[12]});
      check("R9", msr_n, e_msr);
    end else begin
      check("R10", {60'd0, nia_ok, msr_ok, srr0_ok, srr1_ok}, 64'd0);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset idle", {60'd0, nia_ok, msr_ok, srr0_ok, srr1_ok}, 64'd0);

    // corner: address wrap and all-ones state
    @(posedge clk);
    op = 2'b01; cia = '1; msr = '1;
    @(negedge clk);
    verify();
    @(posedge clk);
    op = 2'b10; msr = '0; srr1 = '1; srr0 = '1;
    @(negedge clk);
    verify();

    for (int o = 0; o < 4; o++)
      for (int hv = 0; hv < 2; hv++)
        for (int pr = 0; pr < 2; pr++)
          for (int k = 0; k < 250; k++) begin
            @(posedge clk);
            op   = 2'(o);
            cia  = rnd64();
            srr0 = rnd64();
            msr  = rnd64();
            srr1 = rnd64();
            msr[60]  = 1'(hv);
            srr1[14] = 1'(pr);
            if (k % 4 == 0) srr1[15] = 1'b0;
            if (k % 8 == 1) begin srr1[5] = 1'b0; srr1[4] = 1'b0; end
            @(negedge clk);
            verify();
          end
    done = 1;
    finish_run();
  end

  initial begin
    while (!done && cycles < MAX_CYCLES) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, MAX_CYCLES);
      finish_run();
    end
  end
endmodule